// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block watches an I2C bus on behalf of a slave device and decides whether the bus master is calling it. It synchronizes the SCL and SDA lines to the system clock and detects Start, Repeated Start and Stop. It shifts in the address byte that follows a Start, MSB first, sampling on SCL rising edges, and compares it with a compare register that the host processor writes. When the address matches, the block copies the byte into a receive buffer, pulls SDA low for the acknowledge clock and raises an interrupt flag.

In 10-bit mode two address bytes arrive. After each one is acknowledged, the block holds SCL low and raises an update flag. The host then loads the compare register with the other address byte, and that write releases SCL. After the second byte, the host reloads the high byte. A Repeated Start carrying the high byte with the read bit set can then be matched again. Data-phase transfers are handled elsewhere. Once an address has been handled, the block ignores the bus until the next Start or Stop.

Top module: `i2c_addr_match`

## Requirements
- R1: While `en` is low the block is idle. It does not drive `sda_pull`, and bus traffic sets no flag.
- R2: Address bits are sampled on SCL rising edges, MSB first. On a match the full received byte, including bit 0, appears on `rx_data`.
- R3: In 7-bit mode (`ten_bit` = 0), received bits 7:1 are compared with compare-register bits 7:1. Bit 0 of both is ignored.
- R4: A matching address sets `full_flag` and drives `sda_pull` high throughout the ninth SCL clock. A byte that does not match drives no ACK and sets no flag.
- R5: `irq_flag` rises after the falling edge of the ninth SCL pulse of an acknowledged address and stays set until a one-cycle `irq_clr` pulse.
- R6: A one-cycle `buf_rd` pulse clears `full_flag`.
- R7: A match is refused while `full_flag` or `ovf_flag` is set. A matching byte that arrives while `full_flag` is set sets `ovf_flag` and gets no ACK. `ovf_flag` stays set until `ovf_clr`.
- R8: In 10-bit mode the first byte matches only if its bits 7:3 are 11110, its bits 2:1 equal compare-register bits 2:1, and its bit 0 is 0 (write).
- R9: After each acknowledged 10-bit address byte of the write sequence, `upd_flag` is set and `scl_stretch` holds SCL low from the ninth falling edge. A write to the compare register clears `upd_flag` and releases SCL.
- R10: In 10-bit mode the second byte is compared with all 8 bits of the compare register. A mismatch gets no ACK.
- R11: After the second byte has matched, a Repeated Start followed by the high byte (bits 7:1 equal to the compare register, bit 0 = 1) is acknowledged. It sets `full_flag` and `irq_flag` and leaves `upd_flag` and `scl_stretch` low.
- R12: A Stop returns the block to idle and restarts the 10-bit sequence. A byte sent after the next Start is then treated as a first byte.
- R13: After reset, `sda_pull`, `scl_stretch`, all four flags and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| ten_bit | input | 1 | 1 selects two-byte 10-bit addressing |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (ACK) |
| scl_stretch | output | 1 | 1 holds SCL low |
| addr_wr | input | 1 | Host write strobe for the compare register |
| addr_wdata | input | 8 | Compare register write data |
| buf_rd | input | 1 | Host read strobe for the receive buffer |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| rx_data | output | 8 | Receive buffer |
| full_flag | output | 1 | Receive buffer holds an unread byte |
| ovf_flag | output | 1 | Matching byte arrived while the buffer was full |
| upd_flag | output | 1 | Host must reload the compare register |
| irq_flag | output | 1 | Address acknowledged |

## Verification
A wrong bit count or a wrong shift-register state shows at the ports within one byte time. The ACK is then missing or lands in the wrong SCL clock, and `rx_data` holds a shifted value. A 10-bit sequence register stuck in the wrong step shows only one byte later: the second byte is refused, or a Repeated Start read is answered with a stretch. For this reason the bench runs whole sequences and checks the flags after every byte. A flag with a wrong set or clear priority shows as a stale `full_flag`, `ovf_flag` or `upd_flag` on the next transfer.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

   localparam int BYTE_W = 8;
   localparam int TAG_W  = 5;
   localparam logic [TAG_W-1:0] TEN_TAG = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_HOLD,
      ST_SKIP
   } st_e;

   typedef enum logic [1:0] {
      SQ_HI,
      SQ_LO,
      SQ_REP
   } sq_e;

endpackage

// File: rtl/i2cam_sync.sv
module i2cam_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt,
   output logic sda_bit
);

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic scl_s, sda_s, scl_prev, sda_prev;

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff   <= '1;
         sda_ff   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_in};
         sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_in};
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s     = scl_ff[SYNC_STAGES-1];
   assign sda_s     = sda_ff[SYNC_STAGES-1];
   assign sda_bit   = sda_s;
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2cam_shift.sv
module i2cam_shift
   import i2cam_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start_evt,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_bit,
   output logic [BYTE_W-1:0] shreg,
   output logic              byte_done,
   output logic              ack_end
);

   localparam int CNT_W = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         shreg <= '0;
      end else if (start_evt || !run) begin
         cnt_q <= '0;
      end else if (scl_rise && cnt_q < ACK_SLOT) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q < LAST_DATA) shreg <= {shreg[BYTE_W-2:0], sda_bit};
      end else if (scl_fall && cnt_q == ACK_SLOT) begin
         cnt_q <= '0;
      end
   end

   assign byte_done = run && !start_evt && scl_fall && (cnt_q == LAST_DATA);
   assign ack_end   = run && !start_evt && scl_fall && (cnt_q == ACK_SLOT);

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ACK_SLOT);

endmodule

// File: rtl/i2cam_ctl.sv
module i2cam_ctl
   import i2cam_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mode10,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              byte_done,
   input  logic              ack_end,
   input  logic [BYTE_W-1:0] shreg,
   input  logic              addr_wr,
   input  logic [BYTE_W-1:0] addr_wdata,
   input  logic              buf_rd,
   input  logic              irq_clr,
   input  logic              ovf_clr,
   output logic              run,
   output logic              ack_drv,
   output logic              hold_drv,
   output logic [BYTE_W-1:0] buf_out,
   output logic              full_o,
   output logic              ovf_o,
   output logic              upd_o,
   output logic              irq_o
);

   st_e state_q, state_d;
   sq_e seq_q, seq_d;
   logic [BYTE_W-1:0] addr_q, buf_q;
   logic full_q, ovf_q, irq_q, upd_q, ack_q, hold_pend_q;
   logic seven_ok, tag_ok, hi_ok, lo_ok, hit, in_addr, accept, clash;

   assign in_addr  = (state_q == ST_ADDR);
   assign seven_ok = (shreg[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);
   assign tag_ok   = (shreg[BYTE_W-1 -: TAG_W] == TEN_TAG);
   assign hi_ok    = tag_ok && seven_ok;
   assign lo_ok    = (shreg == addr_q);

   always_comb begin
      if (!mode10) begin
         hit = seven_ok;
      end else begin
         case (seq_q)
            SQ_HI:   hit = hi_ok && !shreg[0];
            SQ_LO:   hit = lo_ok;
            default: hit = hi_ok && shreg[0];
         endcase
      end
   end

   assign accept = byte_done && in_addr && hit && !full_q && !ovf_q;
   assign clash  = byte_done && in_addr && hit && full_q;

   always_comb begin
      state_d = state_q;
      seq_d   = seq_q;
      if (!en || stop_evt) begin
         state_d = ST_IDLE;
         seq_d   = SQ_HI;
      end else if (start_evt) begin
         state_d = ST_ADDR;
      end else begin
         case (state_q)
            ST_ADDR: begin
               if (byte_done) begin
                  if (accept) begin
                     state_d = ST_ACK;
                     if (mode10) seq_d = (seq_q == SQ_HI) ? SQ_LO : SQ_REP;
                  end else begin
                     state_d = ST_SKIP;
                     if (mode10 && seq_q == SQ_LO) seq_d = SQ_HI;
                  end
               end
            end
            ST_ACK:  if (ack_end) state_d = hold_pend_q ? ST_HOLD : ST_SKIP;
            ST_HOLD: if (addr_wr) state_d = ST_ADDR;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         seq_q       <= SQ_HI;
         addr_q      <= '0;
         buf_q       <= '0;
         full_q      <= 1'b0;
         ovf_q       <= 1'b0;
         irq_q       <= 1'b0;
         upd_q       <= 1'b0;
         ack_q       <= 1'b0;
         hold_pend_q <= 1'b0;
      end else begin
         state_q <= state_d;
         seq_q   <= seq_d;
         if (addr_wr) addr_q <= addr_wdata;
         if (accept) begin
            buf_q       <= shreg;
            hold_pend_q <= mode10 && (seq_q != SQ_REP);
         end
         if (accept)      full_q <= 1'b1;
         else if (buf_rd) full_q <= 1'b0;
         if (clash)        ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
         if (accept) ack_q <= 1'b1;
         else if (ack_end || stop_evt || start_evt || !en) ack_q <= 1'b0;
         if (ack_end && ack_q) irq_q <= 1'b1;
         else if (irq_clr)     irq_q <= 1'b0;
         if (ack_end && ack_q && hold_pend_q) upd_q <= 1'b1;
         else if (addr_wr)                    upd_q <= 1'b0;
      end
   end

   assign run      = (state_q == ST_ADDR) || (state_q == ST_ACK) || (state_q == ST_HOLD);
   assign ack_drv  = ack_q;
   assign hold_drv = (state_q == ST_HOLD);
   assign buf_out  = buf_q;
   assign full_o   = full_q;
   assign ovf_o    = ovf_q;
   assign upd_o    = upd_q;
   assign irq_o    = irq_q;

   // R9
   hold_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_drv |-> upd_q);
   // R4
   ack_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> full_q);
   // R7
   ovf_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> !ack_q);
   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(ack_q));
   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && !accept) |=> !full_q);
   // R12
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state_q == ST_IDLE));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2cam_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit TEN_BIT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ten_bit,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic              scl_stretch,
   input  logic              addr_wr,
   input  logic [BYTE_W-1:0] addr_wdata,
   input  logic              buf_rd,
   input  logic              irq_clr,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] rx_data,
   output logic              full_flag,
   output logic              ovf_flag,
   output logic              upd_flag,
   output logic              irq_flag
);

   logic scl_rise, scl_fall, start_evt, stop_evt, sda_bit;
   logic run, byte_done, ack_end, mode_eff;
   logic [BYTE_W-1:0] shreg;

   generate
      if (TEN_BIT_EN) begin : g_ten
         assign mode_eff = ten_bit;
      end else begin : g_seven
         assign mode_eff = 1'b0;
      end
   endgenerate

   i2cam_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .sda_bit   (sda_bit)
   );

   i2cam_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .start_evt (start_evt),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_bit   (sda_bit),
      .shreg     (shreg),
      .byte_done (byte_done),
      .ack_end   (ack_end)
   );

   i2cam_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .mode10     (mode_eff),
      .start_evt  (start_evt),
      .stop_evt   (stop_evt),
      .byte_done  (byte_done),
      .ack_end    (ack_end),
      .shreg      (shreg),
      .addr_wr    (addr_wr),
      .addr_wdata (addr_wdata),
      .buf_rd     (buf_rd),
      .irq_clr    (irq_clr),
      .ovf_clr    (ovf_clr),
      .run        (run),
      .ack_drv    (sda_pull),
      .hold_drv   (scl_stretch),
      .buf_out    (rx_data),
      .full_o     (full_flag),
      .ovf_o      (ovf_flag),
      .upd_o      (upd_flag),
      .irq_o      (irq_flag)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sda_pull);

endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;
   // {ten_bit, compare value, transmitted byte, expected ack}
   localparam logic [17:0] VEC [0:NV-1] = '{
      {1'b0, 8'hA4, 8'hA4, 1'b1},
      {1'b0, 8'hA4, 8'hA5, 1'b1},
      {1'b0, 8'hA4, 8'hA6, 1'b0},
      {1'b0, 8'h00, 8'h01, 1'b1},
      {1'b0, 8'hFF, 8'hFE, 1'b1},
      {1'b0, 8'h5B, 8'hDA, 1'b0},
      {1'b1, 8'hF6, 8'hF6, 1'b1},
      {1'b1, 8'hF6, 8'hF7, 1'b0},
      {1'b1, 8'hF6, 8'hF4, 1'b0},
      {1'b1, 8'hA4, 8'hA4, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0, en = 1'b0, ten_bit = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic addr_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
   logic [7:0] addr_wdata = 8'h00;
   logic sda_pull, scl_stretch, full_flag, ovf_flag, upd_flag, irq_flag;
   logic [7:0] rx_data;
   logic scl_line, sda_line, ackd;
   int total = 0, bad = 0;
   bit finished = 1'b0;

   assign scl_line = scl_m & ~scl_stretch;
   assign sda_line = sda_m & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_addr_match dut (
      .clk(clk), .rst_n(rst_n), .en(en), .ten_bit(ten_bit),
      .scl_in(scl_line), .sda_in(sda_line),
      .sda_pull(sda_pull), .scl_stretch(scl_stretch),
      .addr_wr(addr_wr), .addr_wdata(addr_wdata), .buf_rd(buf_rd),
      .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_data(rx_data),
      .full_flag(full_flag), .ovf_flag(ovf_flag),
      .upd_flag(upd_flag), .irq_flag(irq_flag)
   );

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic raise_scl();
      while (scl_stretch) wclk(1);
      scl_m = 1'b1;
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wclk(5);
      raise_scl(); wclk(10);
      scl_m = 1'b0; wclk(5);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic got_ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wclk(5);
      raise_scl(); wclk(5);
      got_ack = ~sda_line;
      wclk(5);
      scl_m = 1'b0; wclk(5);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; wclk(10);
      scl_m = 1'b0; wclk(5);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; wclk(5);
      raise_scl(); wclk(10);
      sda_m = 1'b0; wclk(10);
      scl_m = 1'b0; wclk(5);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wclk(5);
      raise_scl(); wclk(10);
      sda_m = 1'b1; wclk(10);
   endtask

   task automatic host_addr(input logic [7:0] v);
      addr_wdata = v; addr_wr = 1'b1; wclk(1);
      addr_wr = 1'b0; wclk(1);
   endtask

   task automatic host_rd();
      buf_rd = 1'b1; wclk(1); buf_rd = 1'b0; wclk(1);
   endtask

   task automatic host_iclr();
      irq_clr = 1'b1; wclk(1); irq_clr = 1'b0; wclk(1);
   endtask

   task automatic host_oclr();
      ovf_clr = 1'b1; wclk(1); ovf_clr = 1'b0; wclk(1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin : main
      wclk(3);
      // R13 reset state
      chk("R13 sda_pull", sda_pull, 0);
      chk("R13 scl_stretch", scl_stretch, 0);
      chk("R13 flags", {4'b0, full_flag, ovf_flag, upd_flag, irq_flag}, 0);
      chk("R13 rx_data", rx_data, 0);
      rst_n = 1'b1; en = 1'b1; wclk(3);

      // table walk: R3 R4 R8 R9
      for (int i = 0; i < NV; i++) begin
         logic [17:0] v;
         logic exp_upd;
         v = VEC[i];
         exp_upd = v[17] & v[0];
         ten_bit = v[17];
         host_addr(v[16:9]);
         bus_start();
         send_byte(v[8:1], ackd);
         chk($sformatf("R3/R8 vec%0d ack", i), ackd, v[0]);
         chk($sformatf("R4 vec%0d full", i), full_flag, v[0]);
         chk($sformatf("R5 vec%0d irq", i), irq_flag, v[0]);
         chk($sformatf("R9 vec%0d upd", i), upd_flag, exp_upd);
         chk($sformatf("R9 vec%0d stretch", i), scl_stretch, exp_upd);
         if (v[0]) chk($sformatf("R2 vec%0d rx", i), rx_data, v[8:1]);
         host_addr(v[16:9]);
         host_rd();
         host_iclr();
         chk($sformatf("R6 vec%0d full cleared", i), full_flag, 0);
         chk($sformatf("R5 vec%0d irq cleared", i), irq_flag, 0);
         bus_stop();
      end

      // full 10-bit sequence with Repeated Start read: R9 R10 R11
      ten_bit = 1'b1;
      host_addr(8'hF6);
      bus_start();
      send_byte(8'hF6, ackd);
      chk("R8 hi ack", ackd, 1);
      chk("R9 hi stretch", scl_stretch, 1);
      host_rd(); host_iclr();
      chk("R9 still held before write", scl_stretch, 1);
      host_addr(8'h3C);
      chk("R9 released", scl_stretch, 0);
      chk("R9 upd cleared", upd_flag, 0);
      send_byte(8'h3C, ackd);
      chk("R10 lo ack", ackd, 1);
      chk("R10 rx", rx_data, 8'h3C);
      chk("R9 lo upd", upd_flag, 1);
      chk("R9 lo stretch", scl_stretch, 1);
      host_rd(); host_iclr();
      host_addr(8'hF6);
      bus_rstart();
      send_byte(8'hF7, ackd);
      chk("R11 read ack", ackd, 1);
      chk("R11 full", full_flag, 1);
      chk("R11 irq", irq_flag, 1);
      chk("R11 no upd", upd_flag, 0);
      chk("R11 no stretch", scl_stretch, 0);
      chk("R11 rx", rx_data, 8'hF7);
      host_rd(); host_iclr();
      bus_stop();

      // low byte mismatch: R10
      bus_start();
      send_byte(8'hF6, ackd);
      host_rd(); host_iclr(); host_addr(8'h3C);
      send_byte(8'h3D, ackd);
      chk("R10 mismatch no ack", ackd, 0);
      chk("R10 mismatch full", full_flag, 0);
      chk("R10 mismatch upd", upd_flag, 0);
      bus_stop();

      // Stop restarts the sequence: R12
      host_addr(8'hF6);
      bus_start();
      send_byte(8'hF6, ackd);
      host_rd(); host_iclr(); host_addr(8'h3C);
      bus_stop();
      bus_start();
      send_byte(8'h3C, ackd);
      chk("R12 low byte after stop refused", ackd, 0);
      chk("R12 full", full_flag, 0);
      bus_stop();

      // overflow handling: R7
      ten_bit = 1'b0;
      host_addr(8'hA4);
      bus_start(); send_byte(8'hA4, ackd); bus_stop();
      chk("R7 first ack", ackd, 1);
      bus_start(); send_byte(8'hA4, ackd); bus_stop();
      chk("R7 no ack while full", ackd, 0);
      chk("R7 ovf set", ovf_flag, 1);
      host_rd();
      chk("R7 ovf stays after read", ovf_flag, 1);
      bus_start(); send_byte(8'hA4, ackd); bus_stop();
      chk("R7 no ack while ovf", ackd, 0);
      chk("R7 full stays clear", full_flag, 0);
      host_oclr(); host_iclr();
      chk("R7 ovf cleared", ovf_flag, 0);
      bus_start(); send_byte(8'hA4, ackd); bus_stop();
      chk("R7 ack after clear", ackd, 1);
      host_rd(); host_iclr();

      // disabled: R1
      en = 1'b0; wclk(2);
      bus_start(); send_byte(8'hA4, ackd); bus_stop();
      chk("R1 no ack when disabled", ackd, 0);
      chk("R1 flags when disabled", {4'b0, full_flag, ovf_flag, upd_flag, irq_flag}, 0);
      en = 1'b1; wclk(2);

      summary();
   end

endmodule